// File: doc/BRIEF.md
# Software Recall Sequence Controller

This block sits on the bus of a battery-free static memory and watches for a fixed unlock pattern made of six reads. A read counts only when chip enable frames it: the address and the direction are taken while chip enable is low, and the cycle is judged when chip enable returns high. When the sixth read of the pattern completes, the block starts a recall. A recall first asks a clear engine to wipe the volatile array. It then asks a copy engine to load the saved image into that array. For the whole recall the block raises a busy output, so the surrounding logic can hold off ordinary accesses.

The busy window has a minimum length set by a cycle-count parameter. The window also lasts until the copy engine reports completion, whichever is later. As busy drops, a one-cycle pulse tells the write-tracking logic to clear its flag that records writes since the last save or recall. The recall only reads the saved image, so it can be repeated without limit.

Top module: `recall_seq_ctrl`

## Requirements
- R1: A recall starts only after six completed reads at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and 0x0C63, in exactly that order with no other cycle between them.
- R2: A bus cycle counts as a read when `bus_rd` is 1 while chip enable is low, and it completes on the rising edge of `bus_ce_n`. A write cycle (`bus_rd` 0) returns the matcher to idle.
- R3: Completing the read at 0x0C63 as the sixth step makes `busy` rise on the next clock edge, with `clr_req` high in that first busy cycle.
- R4: The clear request comes first and the copy request follows it. The two are never high together, and the copy request rises only in the cycle after the clear request was high.
- R5: `busy` stays high for at least RECALL_CYCLES cycles and until the copy engine has answered. When both engines answer within one cycle of each request, `busy` lasts exactly RECALL_CYCLES cycles.
- R6: A read whose address is not the expected next step returns the matcher to idle. If that address is 0x0E38, the matcher counts it as step one.
- R7: `recall_done` is high for exactly one cycle: the first cycle in which `busy` is low again.
- R8: While `busy` is high, bus cycles are ignored and the matcher is held at idle. Steps seen during a recall do not count towards the next one.
- R9: The sequence can launch any number of further recalls after the previous one ends.
- R10: Reset leaves `busy`, both requests and `recall_done` low and the matcher idle. A sequence cut short by reset does not launch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Memory bus address |
| bus_ce_n | input | 1 | Active-low chip enable; its rising edge ends a cycle |
| bus_rd | input | 1 | 1 marks the cycle as a read, 0 as a write |
| clr_done | input | 1 | Clear engine reports the array is wiped |
| copy_done | input | 1 | Copy engine reports the image is loaded |
| busy | output | 1 | Recall in progress; bus accesses must wait |
| clr_req | output | 1 | Request to the clear engine |
| copy_req | output | 1 | Request to the copy engine |
| recall_done | output | 1 | One-cycle pulse at recall end; clears the written-since-save flag |

## Verification
The properties check on every cycle that the two engine requests are exclusive and ordered, that every request sits inside the busy window, that a recall opens in the clear phase, that busy never ends before the minimum count, and that the done pulse is single and marks the end of busy. Only the bench scenarios can show which address sequences launch and which do not. These include restarts on a repeated first address, writes inside the pattern, steps issued during a recall, a sequence cut by reset, and the exact busy length with fast and with slow engines.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int SEQ_LEN = 6;
    localparam int ADDR_W  = 16;
    localparam int STEP_W  = $clog2(SEQ_LEN + 1);

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_COPY  = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    // Unlock pattern; the order is behaviour
    function automatic logic [ADDR_W-1:0] seq_addr(input logic [STEP_W-1:0] idx);
        logic [ADDR_W-1:0] a;
        case (idx)
            STEP_W'(0): a = 16'h0E38;
            STEP_W'(1): a = 16'h31C7;
            STEP_W'(2): a = 16'h03E0;
            STEP_W'(3): a = 16'h3C1F;
            STEP_W'(4): a = 16'h303F;
            STEP_W'(5): a = 16'h0C63;
            default:    a = '0;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/rsc_bus_edge.sv
// Captures address and direction while chip enable is low; flags the
// end of each cycle on the rising edge of chip enable.
module rsc_bus_edge
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ce_n,
    input  logic              bus_rd,
    output logic              cyc_end,
    output logic              cyc_read,
    output logic [ADDR_W-1:0] cyc_addr
);

    typedef struct packed {
        logic              ce_n;
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.ce_n = bus_ce_n;
        if (!bus_ce_n) begin
            st_d.rd   = bus_rd;
            st_d.addr = bus_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ce_n: 1'b1, rd: 1'b0, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_end  = !st_q.ce_n && bus_ce_n;
    assign cyc_read = st_q.rd;
    assign cyc_addr = st_q.addr;

endmodule

// File: rtl/rsc_seq_match.sv
// Step counter for the six-read unlock pattern.
module rsc_seq_match
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              cyc_end,
    input  logic              cyc_read,
    input  logic [ADDR_W-1:0] cyc_addr,
    output logic              launch
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } match_t;

    match_t m_d, m_q;
    logic   hit_next;
    logic   hit_first;
    logic   read_end;

    always_comb begin
        hit_next  = (cyc_addr == seq_addr(m_q.step));
        hit_first = (cyc_addr == seq_addr('0));
        read_end  = cyc_end && cyc_read && !hold;
        launch    = read_end && hit_next && (m_q.step == LAST_STEP);

        m_d = m_q;
        if (hold) begin
            m_d.step = '0;
        end else if (cyc_end) begin
            if (!cyc_read) begin
                m_d.step = '0;
            end else if (hit_next) begin
                m_d.step = (m_q.step == LAST_STEP) ? '0 : m_q.step + 1'b1;
            end else if (hit_first) begin
                m_d.step = STEP_W'(1);
            end else begin
                m_d.step = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

endmodule

// File: rtl/rsc_recall_fsm.sv
// Clear, then copy, then hold until the minimum lockout has elapsed.
module rsc_recall_fsm
    import rsc_pkg::*;
#(
    parameter int RECALL_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic clr_done,
    input  logic copy_done,
    output logic busy,
    output logic clr_req,
    output logic copy_req,
    output logic recall_done
);

    localparam int CNT_W = $clog2(RECALL_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(RECALL_CYCLES);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d      = f_q;
        f_d.done = 1'b0;
        if (f_q.ph != PH_IDLE && f_q.cnt != CNT_LIM) begin
            f_d.cnt = f_q.cnt + 1'b1;
        end
        case (f_q.ph)
            PH_IDLE: begin
                if (launch) begin
                    f_d.ph  = PH_CLEAR;
                    f_d.cnt = CNT_W'(1);
                end
            end
            PH_CLEAR: begin
                if (clr_done) f_d.ph = PH_COPY;
            end
            PH_COPY: begin
                if (copy_done) f_d.ph = PH_HOLD;
            end
            PH_HOLD: begin
                if (f_q.cnt == CNT_LIM) begin
                    f_d.ph   = PH_IDLE;
                    f_d.done = 1'b1;
                end
            end
            default: f_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '{ph: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign busy        = (f_q.ph != PH_IDLE);
    assign clr_req     = (f_q.ph == PH_CLEAR);
    assign copy_req    = (f_q.ph == PH_COPY);
    assign recall_done = f_q.done;

endmodule

// File: rtl/recall_seq_ctrl.sv
module recall_seq_ctrl
    import rsc_pkg::*;
#(
    parameter int RECALL_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ce_n,
    input  logic              bus_rd,
    input  logic              clr_done,
    input  logic              copy_done,
    output logic              busy,
    output logic              clr_req,
    output logic              copy_req,
    output logic              recall_done
);

    logic              cyc_end;
    logic              cyc_read;
    logic [ADDR_W-1:0] cyc_addr;
    logic              launch;

    rsc_bus_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_ce_n (bus_ce_n),
        .bus_rd   (bus_rd),
        .cyc_end  (cyc_end),
        .cyc_read (cyc_read),
        .cyc_addr (cyc_addr)
    );

    rsc_seq_match u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (busy),
        .cyc_end  (cyc_end),
        .cyc_read (cyc_read),
        .cyc_addr (cyc_addr),
        .launch   (launch)
    );

    rsc_recall_fsm #(
        .RECALL_CYCLES (RECALL_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .clr_done    (clr_done),
        .copy_done   (copy_done),
        .busy        (busy),
        .clr_req     (clr_req),
        .copy_req    (copy_req),
        .recall_done (recall_done)
    );

endmodule

// File: rtl/rsc_recall_chk.sv
module rsc_recall_chk #(
    parameter int RECALL_CYCLES = 16
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic clr_req,
    input logic copy_req,
    input logic recall_done
);

    int len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= 0;
        end else begin
            len_q <= busy ? len_q + 1 : 0;
        end
    end

    p_excl_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_req && copy_req));

    p_copy_after_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(copy_req) |-> $past(clr_req));

    p_req_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req || copy_req) |-> busy);

    p_open_with_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> clr_req);

    p_min_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (len_q >= RECALL_CYCLES));

    p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        recall_done |-> (!busy && $past(busy)));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        recall_done |=> !recall_done);

endmodule

bind recall_seq_ctrl rsc_recall_chk #(
    .RECALL_CYCLES (RECALL_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .clr_req     (clr_req),
    .copy_req    (copy_req),
    .recall_done (recall_done)
);

// File: tb/tb_recall_seq_ctrl.sv
`timescale 1ns/1ps
module tb_recall_seq_ctrl;

    localparam int NCYC = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_ce_n = 1'b1;
    logic        bus_rd = 1'b1;
    logic        clr_done, copy_done;
    logic        busy, clr_req, copy_req, recall_done;

    int checks = 0;
    int failures = 0;
    int eng_lat = 0;
    int ecnt;

    always #2.5 clk = ~clk;

    recall_seq_ctrl #(.RECALL_CYCLES(NCYC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_ce_n(bus_ce_n),
        .bus_rd(bus_rd), .clr_done(clr_done), .copy_done(copy_done),
        .busy(busy), .clr_req(clr_req), .copy_req(copy_req),
        .recall_done(recall_done)
    );

    // Engine model: answers eng_lat cycles after seeing a request
    always @(posedge clk) begin
        if (!rst_n) begin
            clr_done <= 1'b0; copy_done <= 1'b0; ecnt <= 0;
        end else begin
            clr_done  <= 1'b0;
            copy_done <= 1'b0;
            if ((clr_req && !clr_done) || (copy_req && !copy_done)) begin
                if (ecnt == eng_lat) begin
                    if (clr_req) clr_done <= 1'b1;
                    else         copy_done <= 1'b1;
                    ecnt <= 0;
                end else begin
                    ecnt <= ecnt + 1;
                end
            end else begin
                ecnt <= 0;
            end
        end
    end

    typedef struct packed {
        logic [15:0] addr;
        logic        rd;
        logic        launch;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VECS [NV] = '{
        // R1: clean pattern
        '{16'h0E38,1'b1,1'b0}, '{16'h31C7,1'b1,1'b0}, '{16'h03E0,1'b1,1'b0},
        '{16'h3C1F,1'b1,1'b0}, '{16'h303F,1'b1,1'b0}, '{16'h0C63,1'b1,1'b1},
        // R6: stray address, then full pattern (R9 repeat)
        '{16'h0E38,1'b1,1'b0}, '{16'h31C7,1'b1,1'b0}, '{16'h03E0,1'b1,1'b0},
        '{16'h1234,1'b1,1'b0},
        '{16'h0E38,1'b1,1'b0}, '{16'h31C7,1'b1,1'b0}, '{16'h03E0,1'b1,1'b0},
        '{16'h3C1F,1'b1,1'b0}, '{16'h303F,1'b1,1'b0}, '{16'h0C63,1'b1,1'b1},
        // R6: first address mid-pattern restarts at step one
        '{16'h0E38,1'b1,1'b0}, '{16'h31C7,1'b1,1'b0}, '{16'h0E38,1'b1,1'b0},
        '{16'h31C7,1'b1,1'b0}, '{16'h03E0,1'b1,1'b0}, '{16'h3C1F,1'b1,1'b0},
        '{16'h303F,1'b1,1'b0}, '{16'h0C63,1'b1,1'b1},
        // R2: a write inside the pattern breaks it
        '{16'h0E38,1'b1,1'b0}, '{16'h31C7,1'b1,1'b0}, '{16'h03E0,1'b1,1'b0},
        '{16'h3C1F,1'b0,1'b0}, '{16'h3C1F,1'b1,1'b0}, '{16'h303F,1'b1,1'b0},
        '{16'h0C63,1'b1,1'b0},
        // R6: restart in place of the sixth step
        '{16'h0E38,1'b1,1'b0}, '{16'h31C7,1'b1,1'b0}, '{16'h03E0,1'b1,1'b0},
        '{16'h3C1F,1'b1,1'b0}, '{16'h303F,1'b1,1'b0}, '{16'h0E38,1'b1,1'b0},
        '{16'h31C7,1'b1,1'b0}, '{16'h03E0,1'b1,1'b0}, '{16'h3C1F,1'b1,1'b0},
        '{16'h303F,1'b1,1'b0}, '{16'h0C63,1'b1,1'b1}
    };

    task automatic chk(input bit ok, input string msg);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s", msg);
        end
    endtask

    // One chip-enable framed cycle; returns at the negedge after ce_n rises
    task automatic bus_cycle(input logic [15:0] a, input logic r);
        @(negedge clk);
        bus_ce_n = 1'b0; bus_addr = a; bus_rd = r;
        @(negedge clk);
        @(negedge clk);
        bus_ce_n = 1'b1;
        @(negedge clk);
    endtask

    // Called with busy high at a negedge; returns at the first negedge with busy low
    task automatic wait_recall(input int exp_len, input string tag);
        int  len = 0;
        bit  saw_clr = 0, saw_copy = 0, bad = 0;
        while (busy && len < 1000) begin
            if (clr_req) saw_clr = 1;
            if (copy_req) begin
                saw_copy = 1;
                if (!saw_clr) bad = 1;
            end
            len++;
            @(negedge clk);
        end
        chk(len == exp_len, $sformatf("%s busy length got %0d exp %0d", tag, len, exp_len));
        chk(saw_clr && saw_copy && !bad,
            $sformatf("R4 phase order clr=%0b copy=%0b misorder=%0b exp 1 1 0", saw_clr, saw_copy, bad));
        chk(recall_done == 1'b1, $sformatf("R7 done pulse at end got %0b exp 1", recall_done));
        @(negedge clk);
        chk(recall_done == 1'b0, $sformatf("R7 done pulse width got %0b exp 0", recall_done));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk({busy, clr_req, copy_req, recall_done} == 4'b0000,
            $sformatf("R10 reset outputs got %b exp 0000", {busy, clr_req, copy_req, recall_done}));
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R1, R2, R3, R5, R6, R9
        for (int i = 0; i < NV; i++) begin
            bus_cycle(VECS[i].addr, VECS[i].rd);
            chk(busy == VECS[i].launch,
                $sformatf("R3 vector %0d busy got %0b exp %0b", i, busy, VECS[i].launch));
            if (busy) begin
                chk(clr_req == 1'b1, $sformatf("R3 first busy cycle clr_req got %0b exp 1", clr_req));
                wait_recall(NCYC, "R5");
            end
        end

        // R8: steps during busy do not count
        for (int s = 0; s < 6; s++) bus_cycle(rsc_pkg::seq_addr(3'(s)), 1'b1);
        chk(busy == 1'b1, $sformatf("R8 setup launch got %0b exp 1", busy));
        bus_cycle(16'h0E38, 1'b1);
        bus_cycle(16'h31C7, 1'b1);
        while (busy) @(negedge clk);
        for (int s = 2; s < 6; s++) bus_cycle(rsc_pkg::seq_addr(3'(s)), 1'b1);
        chk(busy == 1'b0, $sformatf("R8 steps during busy counted: busy got %0b exp 0", busy));

        // R5: slow engines stretch busy to 5 + 2*latency cycles
        eng_lat = 10;
        for (int s = 0; s < 6; s++) bus_cycle(rsc_pkg::seq_addr(3'(s)), 1'b1);
        chk(busy == 1'b1, $sformatf("R9 relaunch got %0b exp 1", busy));
        if (busy) wait_recall(25, "R5 slow");
        eng_lat = 0;

        // R10: reset in the middle of a pattern
        for (int s = 0; s < 5; s++) bus_cycle(rsc_pkg::seq_addr(3'(s)), 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_cycle(16'h0C63, 1'b1);
        chk(busy == 1'b0, $sformatf("R10 cut sequence launched: busy got %0b exp 0", busy));

        // R1: out-of-order pattern does not launch
        bus_cycle(16'h31C7, 1'b1);
        bus_cycle(16'h0E38, 1'b1);
        bus_cycle(16'h03E0, 1'b1);
        bus_cycle(16'h3C1F, 1'b1);
        bus_cycle(16'h303F, 1'b1);
        bus_cycle(16'h0C63, 1'b1);
        chk(busy == 1'b0, $sformatf("R1 wrong order busy got %0b exp 0", busy));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule